// File: doc/BRIEF.md
# STS-1 Time-Slot Cross-Connect

This block is a nonblocking time-slot switch for byte-interleaved STS-1 streams. It serves two classes of line port. Each wide port carries four times as many STS-1 slots as a narrow port. It delivers them four bytes per clock where a narrow port delivers one. Frames are already aligned at the ports. One frame pulse marks the first byte time of every frame, and a frame lasts `LS_SLOTS` clocks. Every STS-1 that arrives in a frame goes into one bank of a two-bank frame store. During the following frame, each output slot reads whichever stored input slot its connection entry names. Any input slot can therefore reach any output slot on any port, and one input slot can feed any number of outputs at once.

Each output slot has a connection entry of {valid, source port, source slot}. Writes land in a shadow copy. The whole shadow copy becomes active only at a frame pulse, so an output frame is never switched with a half-updated map. An output slot with no valid entry, or whose entry names a slot that does not exist, sends the all-ones unequipped byte. Byte content passes through untouched.

Top module: `xc_sts_switch`

## Requirements
- R1: Any input slot on any port, wide or narrow, can be routed to any output slot on any port, and the byte reaches the output unchanged.
- R2: `fp_o` is high exactly one clock after `fp_i` was high. The output frame that `fp_o` opens carries the bytes of the input frame that ended just before it.
- R3: Within a frame, byte time c (with c = 0 at `fp_i`) carries slot c on a narrow port. On a wide port it carries slots 4c+l on lanes l = 0..3, where lane l sits at bits [8l+7:8l] of that port's 32-bit field. Wide ports are ports 0..N_HS-1 and narrow ports follow. Port fields are packed from bit 0 upward.
- R4: One input slot can feed several output slots in the same frame, and each of them carries the same byte.
- R5: An output slot whose entry is not valid, or whose entry names a port that does not exist or a slot beyond that port's capacity, outputs 8'hFF.
- R6: A connection write changes only the shadow map. The shadow map is copied to the active map in the clock where `fp_i` is high, and a write made in that same clock waits for the next `fp_i`.
- R7: A write whose output port does not exist, or whose output slot is beyond that port's capacity, changes no entry.
- R8: While reset is asserted, every output byte is 8'hFF, `fp_o` is low, and every connection entry is invalid.
- R9: Every output slot of every port can be mapped at the same time, and every one of them carries its selected byte with no contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Marks byte time 0 of an input frame |
| hs_din | input | N_HS*4*8 | Wide-port input bytes, four lanes per port |
| ls_din | input | N_LS*8 | Narrow-port input bytes |
| cfg_we | input | 1 | Connection write strobe |
| cfg_oport | input | PW | Output port of the entry written |
| cfg_oslot | input | SW | Output slot of the entry written |
| cfg_valid | input | 1 | Valid flag of the entry written |
| cfg_iport | input | PW | Source port of the entry written |
| cfg_islot | input | SW | Source slot of the entry written |
| fp_o | output | 1 | Marks byte time 0 of an output frame |
| hs_dout | output | N_HS*4*8 | Wide-port output bytes |
| ls_dout | output | N_LS*8 | Narrow-port output bytes |

## Verification
Inputs and the frame pulse pass through one register stage. Because of that, `fp_o` and the output bytes for byte time c appear right after the clock edge that takes input byte time c of the next frame. The bench drives each byte time on the falling edge and compares every output lane 1 ns after the following rising edge. Each lane is compared against the previous input frame's data, looked up through the bench's own active map. The bench copies its shadow map to its active map in the clock where it raises `fp_i`, before it applies that clock's write. This makes a write in the pulse clock appear one frame later than a write made in any other clock.

// File: rtl/xc_sts_pkg.sv
package xc_sts_pkg;

  // Number of STS-1 slots a port carries per frame.
  function automatic int port_cap(int port, int n_hs, int hs_slots, int ls_slots);
    return (port < n_hs) ? hs_slots : ls_slots;
  endfunction

  // True when (port, slot) names a slot that exists.
  function automatic logic slot_exists(int port, int slot, int n_hs, int n_ls,
                                       int hs_slots, int ls_slots);
    return (port < n_hs + n_ls) && (slot < port_cap(port, n_hs, hs_slots, ls_slots));
  endfunction

  // Flat position of a slot: wide ports first, then narrow ports.
  function automatic int flat_slot(int port, int slot, int n_hs, int hs_slots, int ls_slots);
    if (port < n_hs) return port * hs_slots + slot;
    return n_hs * hs_slots + (port - n_hs) * ls_slots + slot;
  endfunction

endpackage

// File: rtl/xc_frame_ctr.sv
module xc_frame_ctr #(
  parameter int LS_SLOTS = 3,
  parameter int POSW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_i,
  output logic            fp_q,
  output logic [POSW-1:0] pos_q,
  output logic            bank_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q   <= 1'b0;
      pos_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      fp_q <= fp_i;
      if (fp_i) begin
        pos_q  <= '0;
        bank_q <= ~bank_q;
      end else if (pos_q == POSW'(LS_SLOTS - 1)) begin
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) < LS_SLOTS);

  // R2
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |-> bank_q != $past(bank_q));

endmodule

// File: rtl/xc_frame_buf.sv
module xc_frame_buf #(
  parameter int NL  = 12,
  parameter int TOT = 36,
  parameter int FW  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_bank,
  input  logic [NL-1:0][FW-1:0]  wr_idx,
  input  logic [NL-1:0][7:0]     din,
  input  logic                   rd_bank,
  input  logic [NL-1:0][FW-1:0]  rd_idx,
  output logic [NL-1:0][7:0]     rd_data
);

  logic [7:0] mem [2][TOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < TOT; i++)
          mem[b][i] <= '0;
    end else begin
      for (int ln = 0; ln < NL; ln++)
        mem[wr_bank][wr_idx[ln]] <= din[ln];
    end
  end

  always_comb begin
    for (int ln = 0; ln < NL; ln++)
      rd_data[ln] = mem[rd_bank][rd_idx[ln]];
  end

endmodule

// File: rtl/xc_conn_ram.sv
module xc_conn_ram #(
  parameter int TOT = 36,
  parameter int FW  = 6,
  parameter int EW  = 8,
  parameter int NL  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   swap,
  input  logic                   wr_en,
  input  logic [FW-1:0]          wr_idx,
  input  logic [EW-1:0]          wr_entry,
  input  logic [NL-1:0][FW-1:0]  rd_idx,
  output logic [NL-1:0][EW-1:0]  rd_entry
);

  logic [TOT-1:0][EW-1:0] shadow_q;
  logic [TOT-1:0][EW-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) shadow_q[wr_idx] <= wr_entry;
      if (swap)  active_q <= shadow_q;
    end
  end

  always_comb begin
    for (int ln = 0; ln < NL; ln++)
      rd_entry[ln] = active_q[rd_idx[ln]];
  end

  // R6
  load_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> active_q == $past(shadow_q));

  // R6
  hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(active_q));

endmodule

// File: rtl/xc_sts_switch.sv
module xc_sts_switch
  import xc_sts_pkg::*;
#(
  parameter int N_HS     = 2,
  parameter int N_LS     = 4,
  parameter int LS_SLOTS = 3,
  parameter int HS_RATIO = 4,
  parameter int NP       = N_HS + N_LS,
  parameter int HS_SLOTS = HS_RATIO * LS_SLOTS,
  parameter int PW       = (NP > 1) ? $clog2(NP) : 1,
  parameter int SW       = (HS_SLOTS > 1) ? $clog2(HS_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fp_i,
  input  logic [N_HS*HS_RATIO*8-1:0] hs_din,
  input  logic [N_LS*8-1:0]          ls_din,
  input  logic                       cfg_we,
  input  logic [PW-1:0]              cfg_oport,
  input  logic [SW-1:0]              cfg_oslot,
  input  logic                       cfg_valid,
  input  logic [PW-1:0]              cfg_iport,
  input  logic [SW-1:0]              cfg_islot,
  output logic                       fp_o,
  output logic [N_HS*HS_RATIO*8-1:0] hs_dout,
  output logic [N_LS*8-1:0]          ls_dout
);

  localparam int HS_LANES = N_HS * HS_RATIO;
  localparam int NL       = HS_LANES + N_LS;
  localparam int TOT      = N_HS * HS_SLOTS + N_LS * LS_SLOTS;
  localparam int FW       = (TOT > 1) ? $clog2(TOT) : 1;
  localparam int EW       = 1 + PW + SW;
  localparam int POSW     = (LS_SLOTS > 1) ? $clog2(LS_SLOTS) : 1;

  logic                  fp_q;
  logic [POSW-1:0]       pos_q;
  logic                  bank_q;
  logic [NL-1:0][7:0]    din_q;
  logic [NL-1:0][FW-1:0] lane_idx;
  logic [NL-1:0][FW-1:0] src_idx;
  logic [NL-1:0][EW-1:0] ent_rd;
  logic [NL-1:0][7:0]    buf_rd;
  logic [NL-1:0][7:0]    out_lane;
  logic                  cfg_wr_en;
  logic [FW-1:0]         cfg_wr_idx;

  // Input register stage, aligned with the registered frame position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= {ls_din, hs_din};
  end

  xc_frame_ctr #(.LS_SLOTS(LS_SLOTS), .POSW(POSW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i),
    .fp_q(fp_q), .pos_q(pos_q), .bank_q(bank_q)
  );

  // Connection write path: out-of-range destinations are dropped.
  assign cfg_wr_en  = cfg_we && slot_exists(int'(cfg_oport), int'(cfg_oslot),
                                            N_HS, N_LS, HS_SLOTS, LS_SLOTS);
  assign cfg_wr_idx = FW'(flat_slot(int'(cfg_oport), int'(cfg_oslot),
                                    N_HS, HS_SLOTS, LS_SLOTS));

  xc_conn_ram #(.TOT(TOT), .FW(FW), .EW(EW), .NL(NL)) u_cram (
    .clk(clk), .rst_n(rst_n), .swap(fp_i),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
    .wr_entry({cfg_valid, cfg_iport, cfg_islot}),
    .rd_idx(lane_idx), .rd_entry(ent_rd)
  );

  xc_frame_buf #(.NL(NL), .TOT(TOT), .FW(FW)) u_fbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_bank(bank_q), .wr_idx(lane_idx), .din(din_q),
    .rd_bank(~bank_q), .rd_idx(src_idx), .rd_data(buf_rd)
  );

  for (genvar ln = 0; ln < NL; ln++) begin : g_lane
    localparam int PORT = (ln < HS_LANES) ? ln / HS_RATIO : N_HS + ln - HS_LANES;
    localparam int SUB  = (ln < HS_LANES) ? ln % HS_RATIO : 0;
    localparam int MUL  = (ln < HS_LANES) ? HS_RATIO : 1;

    logic          ent_v;
    logic [PW-1:0] ent_p;
    logic [SW-1:0] ent_s;
    logic          src_ok;

    // The same flat slot serves as write target and as output position.
    assign lane_idx[ln] = FW'(flat_slot(PORT, int'(pos_q) * MUL + SUB,
                                        N_HS, HS_SLOTS, LS_SLOTS));
    assign {ent_v, ent_p, ent_s} = ent_rd[ln];
    assign src_ok = ent_v && slot_exists(int'(ent_p), int'(ent_s),
                                         N_HS, N_LS, HS_SLOTS, LS_SLOTS);
    assign src_idx[ln] = src_ok ? FW'(flat_slot(int'(ent_p), int'(ent_s),
                                                N_HS, HS_SLOTS, LS_SLOTS)) : '0;
    assign out_lane[ln] = src_ok ? buf_rd[ln] : 8'hFF;

    // R5
    unequipped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_v |-> out_lane[ln] == 8'hFF);
  end

  assign fp_o    = fp_q;
  assign hs_dout = out_lane[HS_LANES-1:0];
  assign ls_dout = out_lane[NL-1:HS_LANES];

  // R2
  frame_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> fp_o);

endmodule

// File: tb/xc_sts_switch_tb.sv
module xc_sts_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_HS = 2;
  localparam int N_LS = 4;
  localparam int LSS  = 3;
  localparam int RAT  = 4;
  localparam int HSS  = RAT * LSS;
  localparam int NP   = N_HS + N_LS;
  localparam int NV   = 14;

  // Vector: {we, valid, oport[3], oslot[4], iport[3], islot[4]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd0, 4'd0,  3'd5, 4'd2},   // wide0 s0 <- narrow3 s2, written in pulse clock
    {1'b1, 1'b1, 3'd2, 4'd1,  3'd1, 4'd11},  // narrow0 s1 <- wide1 s11
    {1'b1, 1'b1, 3'd1, 4'd5,  3'd0, 4'd7},   // fan-out leg 1
    {1'b1, 1'b1, 3'd4, 4'd0,  3'd0, 4'd7},   // fan-out leg 2
    {1'b1, 1'b1, 3'd3, 4'd2,  3'd0, 4'd7},   // fan-out leg 3
    {1'b1, 1'b1, 3'd0, 4'd11, 3'd2, 4'd0},   // wide0 s11 <- narrow0 s0
    {1'b1, 1'b1, 3'd3, 4'd1,  3'd5, 4'd5},   // source slot beyond capacity
    {1'b1, 1'b1, 3'd1, 4'd0,  3'd7, 4'd0},   // source port absent
    {1'b1, 1'b1, 3'd5, 4'd0,  3'd1, 4'd3},   // narrow3 s0 <- wide1 s3
    {1'b1, 1'b1, 3'd4, 4'd3,  3'd0, 4'd0},   // dest slot beyond capacity
    {1'b1, 1'b1, 3'd7, 4'd0,  3'd0, 4'd1},   // dest port absent
    {1'b1, 1'b0, 3'd0, 4'd0,  3'd0, 4'd0},   // clear wide0 s0
    {1'b1, 1'b1, 3'd0, 4'd4,  3'd2, 4'd2},   // wide0 s4 <- narrow0 s2
    {1'b0, 1'b0, 3'd0, 4'd0,  3'd0, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp_i = 1'b0;
  logic [N_HS*RAT*8-1:0] hs_din = '0;
  logic [N_LS*8-1:0] ls_din = '0;
  logic cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [2:0] cfg_oport = '0, cfg_iport = '0;
  logic [3:0] cfg_oslot = '0, cfg_islot = '0;
  logic fp_o;
  logic [N_HS*RAT*8-1:0] hs_dout;
  logic [N_LS*8-1:0] ls_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  xc_sts_switch u_dut (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .hs_din(hs_din), .ls_din(ls_din),
    .cfg_we(cfg_we), .cfg_oport(cfg_oport), .cfg_oslot(cfg_oslot),
    .cfg_valid(cfg_valid), .cfg_iport(cfg_iport), .cfg_islot(cfg_islot),
    .fp_o(fp_o), .hs_dout(hs_dout), .ls_dout(ls_dout)
  );

  int n_chk = 0;
  int n_bad = 0;
  int g = 0;
  string extra = "";
  bit s_v [NP][HSS];
  int s_p [NP][HSS];
  int s_s [NP][HSS];
  bit a_v [NP][HSS];
  int a_p [NP][HSS];
  int a_s [NP][HSS];

  function automatic int cap(int p);
    return (p < N_HS) ? HSS : LSS;
  endfunction

  function automatic logic [7:0] dval(int fr, int p, int s);
    return 8'((fr * 13 + p * 12 + s) % 128);
  endfunction

  function automatic logic [7:0] expect_byte(int fr, int op, int os);
    if (!a_v[op][os]) return 8'hFF;
    if (a_p[op][os] >= NP || a_s[op][os] >= cap(a_p[op][os])) return 8'hFF;
    return dval(fr, a_p[op][os], a_s[op][os]);
  endfunction

  function automatic int fanout(int ip, int is);
    int n = 0;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < cap(p); s++)
        if (a_v[p][s] && a_p[p][s] == ip && a_s[p][s] == is) n++;
    return n;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, g);
    end
  endtask

  task automatic step(bit we, int op, int os, bit v, int ip, int is);
    int pos;
    int fr;
    logic [7:0] got;
    logic [7:0] exp;
    int sl;
    string tag;
    @(negedge clk);
    pos = g % LSS;
    fr  = g / LSS;
    fp_i = (pos == 0);
    for (int p = 0; p < N_HS; p++)
      for (int l = 0; l < RAT; l++)
        hs_din[(p*RAT+l)*8 +: 8] = dval(fr, p, pos*RAT + l);
    for (int q = 0; q < N_LS; q++)
      ls_din[q*8 +: 8] = dval(fr, N_HS + q, pos);
    cfg_we = we; cfg_valid = v;
    cfg_oport = 3'(op); cfg_oslot = 4'(os);
    cfg_iport = 3'(ip); cfg_islot = 4'(is);
    // R6: shadow copied at the pulse before this clock's write lands
    if (pos == 0) begin
      a_v = s_v; a_p = s_p; a_s = s_s;
    end
    if (we && op < NP && os < cap(op)) begin
      s_v[op][os] = v; s_p[op][os] = ip; s_s[op][os] = is;
    end
    @(posedge clk);
    #1;
    check({"R2", extra}, 32'(fp_o), 32'(pos == 0));
    if (fr >= 1) begin
      for (int op2 = 0; op2 < NP; op2++) begin
        for (int l = 0; l < ((op2 < N_HS) ? RAT : 1); l++) begin
          sl  = (op2 < N_HS) ? pos*RAT + l : pos;
          got = (op2 < N_HS) ? hs_dout[(op2*RAT+l)*8 +: 8] : ls_dout[(op2-N_HS)*8 +: 8];
          exp = expect_byte(fr - 1, op2, sl);
          if (exp == 8'hFF) tag = "R5";
          else if (fanout(a_p[op2][sl], a_s[op2][sl]) > 1) tag = "R4";
          else tag = "R1 R3 R6";
          check({tag, extra}, 32'(got), 32'(exp));
        end
      end
    end
    g++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] e;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < HSS; s++) begin
        s_v[p][s] = 0; s_p[p][s] = 0; s_s[p][s] = 0;
        a_v[p][s] = 0; a_p[p][s] = 0; a_s[p][s] = 0;
      end
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8", 32'(fp_o), 32'd0);
    check("R8", 32'(hs_dout == '1), 32'd1);
    check("R8", 32'(ls_dout == '1), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table walk, then idle frames to observe it
    for (int k = 0; k < NV; k++) begin
      e = VEC[k];
      step(e[15], int'(e[13:11]), int'(e[10:7]), e[14], int'(e[6:4]), int'(e[3:0]));
    end
    repeat (3 * LSS) step(0, 0, 0, 0, 0, 0);

    // R7: narrow3 slot0 keeps its mapping after an aliasing out-of-range write
    while (g % LSS != 1) step(0, 0, 0, 0, 0, 0);
    check("R7", 32'(ls_dout[3*8 +: 8]), 32'(dval((g-1)/LSS - 1, 1, 3)));

    // R9: every output slot mapped at once
    extra = " R9";
    for (int op = 0; op < NP; op++)
      for (int os = 0; os < cap(op); os++)
        step(1, op, os, 1, NP - 1 - op, os % cap(NP - 1 - op));
    repeat (3 * LSS) step(0, 0, 0, 0, 0, 0);
    extra = "";

    // R8: reset applied mid-run forces unequipped outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", 32'(fp_o), 32'd0);
    check("R8", 32'(hs_dout == '1), 32'd1);
    check("R8", 32'(ls_dout == '1), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule